// File: doc/BRIEF.md
# Prefix-Length Binary Search Lookup

The block resolves a destination address to an output port by longest-prefix match. It keeps one small hashed table for every prefix length from 1 to the address width. Instead of trying every length in turn, it binary-searches over the lengths. Each step reads exactly one table in one clock cycle.

Software fills the tables through a configuration write port. A table entry holds two kinds of information, and either or both may be present in one entry:
- A real route.
- A marker. A marker is placed at a shorter length on the search path toward a longer route. It tells the search that a longer match may exist.

Each entry carries a "has port" flag and a best-matching port. For a real route, that port is the route's own port. For a marker-only entry, it is the precomputed port of the longest real route that covers the marker, if such a route exists.

The search steps as follows:
- A probe that finds an entry moves the search toward longer lengths.
- A probe that finds nothing moves it toward shorter lengths.
- The answer is the port carried by the last entry found that has a port.

Lookups use a valid/ready request and a valid/ready response. The response is held until it is taken. Configuration writes take effect only while the block is idle.

Top module: `lpm_bsearch_lookup`

## Requirements
- R1: After reset, req_ready is 1 and resp_valid is 0.
- R2: The response reports resp_hit=1 and the port of the longest real route whose top len bits equal the address's top len bits. If no route covers the address, it reports resp_hit=0.
- R3: A request is accepted on the edge where req_valid and req_ready are both high. The block then makes one table probe per clock edge. resp_valid goes high after at least 1 and at most $clog2(AW)+1 probe edges (5 for AW=16). The probe lengths follow a binary search starting at lo=1, hi=AW, with mid=(lo+hi)/2.
- R4: Finding an entry moves the search to longer lengths (lo=mid+1), and finding nothing moves it to shorter ones (hi=mid-1). An entry with cfg_has_port=0 steers the search but supplies no port. The result is taken from the last entry found with cfg_has_port=1.
- R5: An entry of length len lives in bucket idx of that length's table. idx is the XOR of the masked key split into IDXW-bit chunks starting at bit 0, with the top chunk zero-padded. The writer picks the slot with cfg_slot. A probe compares all slots of the bucket and matches only on equal key and equal length tag.
- R6: Key bits below the prefix length (bits AW-1-len down to 0) are cleared before the key is stored and hashed. They have no effect on matching.
- R7: A write with cfg_live=0 removes the entry in the addressed slot, and later lookups no longer match it.
- R8: A configuration write is ignored unless the block is idle (req_ready=1). A write during a search leaves the tables unchanged.
- R9: While resp_valid=1 and resp_ready=0, resp_valid, resp_hit and resp_port stay unchanged. req_ready stays 0 from acceptance until the response is taken, and returns to 1 on the edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block idle, request can be accepted |
| req_addr | input | AW | Destination address to resolve |
| resp_valid | output | 1 | Lookup result available |
| resp_ready | input | 1 | Result taken |
| resp_hit | output | 1 | A route covered the address |
| resp_port | output | PW | Port of the longest matching route |
| cfg_wr | input | 1 | Table write strobe |
| cfg_len | input | LW | Prefix length of the entry, 1..AW |
| cfg_slot | input | SW | Slot within the bucket |
| cfg_key | input | AW | Entry key, masked to cfg_len inside |
| cfg_live | input | 1 | 1 writes the entry, 0 removes it |
| cfg_has_port | input | 1 | Entry carries a best-matching port |
| cfg_port | input | PW | Best-matching port of the entry |

## Verification
The bench loads a route set designed to exercise the search. It contains nested prefixes, a full-length route, a marker-only path with no covering route, and gaps that must miss. It then sweeps 4096 addresses covering every combination of the top twelve bits. Each result is compared with an arithmetic longest-prefix reference. This separates a correct search from one that goes the wrong direction, loses a marker's port, or uses a wrong hash.

Directed lookups check the following:
- Addresses that find a marker and then miss longer, which must fall back to the marker's port or to a miss.
- The worst-case probe count on the full-length route.
- Response holding while resp_ready is low.
- A write issued during a search, which must not take effect.
- A write whose key has junk low bits.
- A delete.

// File: rtl/lpm_bs_pkg.sv
package lpm_bs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_DONE   = 2'd2
  } lpm_state_e;
endpackage

// File: rtl/lpm_key_hash.sv
// Masks an address to a prefix length and folds the masked key into a bucket index.
module lpm_key_hash #(
  parameter int AW   = 16,
  parameter int LW   = 5,
  parameter int IDXW = 3
) (
  input  logic [AW-1:0]   addr,
  input  logic [LW-1:0]   len,
  output logic [AW-1:0]   key,
  output logic [IDXW-1:0] idx
);
  logic [AW-1:0] mask;

  always_comb begin
    for (int i = 0; i < AW; i++) begin
      mask[AW-1-i] = (i < int'(len));
    end
    key = addr & mask;
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < AW; i += IDXW) begin
      idx = idx ^ IDXW'(key >> i);
    end
  end
endmodule

// File: rtl/lpm_len_tables.sv
// One hashed table per prefix length; one bucket read per cycle, all slots compared.
module lpm_len_tables #(
  parameter int AW    = 16,
  parameter int PW    = 4,
  parameter int LW    = 5,
  parameter int IDXW  = 3,
  parameter int NSLOT = 4,
  parameter int SW    = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [LW-1:0]   wr_len,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [SW-1:0]   wr_slot,
  input  logic [AW-1:0]   wr_key,
  input  logic            wr_live,
  input  logic            wr_has_port,
  input  logic [PW-1:0]   wr_port,
  input  logic [LW-1:0]   rd_len,
  input  logic [IDXW-1:0] rd_idx,
  input  logic [AW-1:0]   rd_key,
  output logic            rd_hit,
  output logic            rd_has_port,
  output logic [PW-1:0]   rd_port
);
  localparam int NB  = 1 << IDXW;
  localparam int LIW = (AW > 1) ? $clog2(AW) : 1;

  logic          ent_live [AW][NB][NSLOT];
  logic [AW-1:0] ent_key  [AW][NB][NSLOT];
  logic [LW-1:0] ent_len  [AW][NB][NSLOT];
  logic          ent_hasp [AW][NB][NSLOT];
  logic [PW-1:0] ent_port [AW][NB][NSLOT];

  logic [LIW-1:0]  wr_li, rd_li;
  logic [NSLOT-1:0] slot_hit;

  assign wr_li = LIW'(wr_len - LW'(1));
  assign rd_li = LIW'(rd_len - LW'(1));

  // valid bits carry reset; payload does not
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < AW; l++)
        for (int b = 0; b < NB; b++)
          for (int s = 0; s < NSLOT; s++)
            ent_live[l][b][s] <= 1'b0;
    end else if (wr_en) begin
      ent_live[wr_li][wr_idx][wr_slot] <= wr_live;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_key [wr_li][wr_idx][wr_slot] <= wr_key;
      ent_len [wr_li][wr_idx][wr_slot] <= wr_len;
      ent_hasp[wr_li][wr_idx][wr_slot] <= wr_has_port;
      ent_port[wr_li][wr_idx][wr_slot] <= wr_port;
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_cmp
    assign slot_hit[s] = ent_live[rd_li][rd_idx][s]
                      && (ent_key[rd_li][rd_idx][s] == rd_key)
                      && (ent_len[rd_li][rd_idx][s] == rd_len);
  end

  // lowest matching slot wins
  always_comb begin
    rd_hit      = 1'b0;
    rd_has_port = 1'b0;
    rd_port     = '0;
    for (int s = NSLOT - 1; s >= 0; s--) begin
      if (slot_hit[s]) begin
        rd_hit      = 1'b1;
        rd_has_port = ent_hasp[rd_li][rd_idx][s];
        rd_port     = ent_port[rd_li][rd_idx][s];
      end
    end
  end
endmodule

// File: rtl/lpm_bs_ctrl.sv
// Binary search sequencer over prefix lengths with request/response handshakes.
module lpm_bs_ctrl
  import lpm_bs_pkg::*;
#(
  parameter int AW = 16,
  parameter int PW = 4,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          resp_valid,
  input  logic          resp_ready,
  output logic          resp_hit,
  output logic [PW-1:0] resp_port,
  output logic [LW-1:0] probe_len,
  output logic [AW-1:0] probe_addr,
  input  logic          pr_hit,
  input  logic          pr_has_port,
  input  logic [PW-1:0] pr_port
);
  lpm_state_e    st_q, st_d;
  logic [LW-1:0] lo_q, lo_d, hi_q, hi_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          found_q, found_d;
  logic [PW-1:0] best_q, best_d;
  logic [LW:0]   mid_sum;
  logic [LW-1:0] mid;
  logic          data_en;

  assign mid_sum = {1'b0, lo_q} + {1'b0, hi_q};
  assign mid     = LW'(mid_sum >> 1);

  always_comb begin
    st_d    = st_q;
    lo_d    = lo_q;
    hi_d    = hi_q;
    addr_d  = addr_q;
    found_d = found_q;
    best_d  = best_q;
    data_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          data_en = 1'b1;
          addr_d  = req_addr;
          lo_d    = LW'(1);
          hi_d    = LW'(AW);
          found_d = 1'b0;
          best_d  = '0;
          st_d    = ST_SEARCH;
        end
      end
      ST_SEARCH: begin
        data_en = 1'b1;
        if (pr_hit) begin
          lo_d = mid + LW'(1);
          if (pr_has_port) begin
            found_d = 1'b1;
            best_d  = pr_port;
          end
        end else begin
          hi_d = mid - LW'(1);
        end
        if (lo_d > hi_d) st_d = ST_DONE;
      end
      ST_DONE: begin
        if (resp_ready) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      lo_q    <= '0;
      hi_q    <= '0;
      addr_q  <= '0;
      found_q <= 1'b0;
      best_q  <= '0;
    end else begin
      st_q <= st_d;
      if (data_en) begin
        lo_q    <= lo_d;
        hi_q    <= hi_d;
        addr_q  <= addr_d;
        found_q <= found_d;
        best_q  <= best_d;
      end
    end
  end

  assign req_ready  = (st_q == ST_IDLE);
  assign resp_valid = (st_q == ST_DONE);
  assign resp_hit   = found_q;
  assign resp_port  = best_q;
  assign probe_len  = mid;
  assign probe_addr = addr_q;
endmodule

// File: rtl/lpm_bsearch_lookup.sv
module lpm_bsearch_lookup #(
  parameter  int AW    = 16,
  parameter  int PW    = 4,
  parameter  int IDXW  = 3,
  parameter  int NSLOT = 4,
  localparam int LW    = $clog2(AW + 2),
  localparam int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          resp_valid,
  input  logic          resp_ready,
  output logic          resp_hit,
  output logic [PW-1:0] resp_port,
  input  logic          cfg_wr,
  input  logic [LW-1:0] cfg_len,
  input  logic [SW-1:0] cfg_slot,
  input  logic [AW-1:0] cfg_key,
  input  logic          cfg_live,
  input  logic          cfg_has_port,
  input  logic [PW-1:0] cfg_port
);
  logic [LW-1:0]   probe_len;
  logic [AW-1:0]   probe_addr, probe_key, wr_key;
  logic [IDXW-1:0] probe_idx, wr_idx;
  logic            pr_hit, pr_has_port;
  logic [PW-1:0]   pr_port;
  logic            wr_en;

  assign wr_en = cfg_wr && req_ready && (cfg_len != '0) && (cfg_len <= LW'(AW));

  lpm_bs_ctrl #(.AW(AW), .PW(PW), .LW(LW)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_hit(resp_hit), .resp_port(resp_port),
    .probe_len(probe_len), .probe_addr(probe_addr),
    .pr_hit(pr_hit), .pr_has_port(pr_has_port), .pr_port(pr_port)
  );

  lpm_key_hash #(.AW(AW), .LW(LW), .IDXW(IDXW)) probe_hash_i (
    .addr(probe_addr), .len(probe_len), .key(probe_key), .idx(probe_idx)
  );

  lpm_key_hash #(.AW(AW), .LW(LW), .IDXW(IDXW)) cfg_hash_i (
    .addr(cfg_key), .len(cfg_len), .key(wr_key), .idx(wr_idx)
  );

  lpm_len_tables #(.AW(AW), .PW(PW), .LW(LW), .IDXW(IDXW), .NSLOT(NSLOT), .SW(SW)) tables_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_len(cfg_len), .wr_idx(wr_idx), .wr_slot(cfg_slot),
    .wr_key(wr_key), .wr_live(cfg_live), .wr_has_port(cfg_has_port), .wr_port(cfg_port),
    .rd_len(probe_len), .rd_idx(probe_idx), .rd_key(probe_key),
    .rd_hit(pr_hit), .rd_has_port(pr_has_port), .rd_port(pr_port)
  );
endmodule

// File: rtl/lpm_bs_chk.sv
module lpm_bs_chk #(
  parameter int AW = 16,
  parameter int PW = 4,
  parameter int LW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          resp_valid,
  input logic          resp_ready,
  input logic          resp_hit,
  input logic [PW-1:0] resp_port,
  input logic [LW-1:0] probe_len
);
  localparam int MAXP = $clog2(AW) + 1;
  localparam int CW   = $clog2(MAXP + 2) + 1;

  logic [CW-1:0] probe_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      probe_cnt <= '0;
    end else if (req_valid && req_ready) begin
      probe_cnt <= '0;
    end else if (!req_ready && !resp_valid) begin
      probe_cnt <= probe_cnt + CW'(1);
    end
  end

  // R3
  probe_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready && !resp_valid |-> probe_cnt < CW'(MAXP));

  // R3
  probe_len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready && !resp_valid |-> (probe_len >= LW'(1)) && (probe_len <= LW'(AW)));

  // R9
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_hit) && $stable(resp_port));

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R9
  release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_ready |=> req_ready && !resp_valid);

  // R1
  ready_valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && resp_valid));
endmodule

bind lpm_bsearch_lookup lpm_bs_chk #(.AW(AW), .PW(PW), .LW(LW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_hit(resp_hit),
  .resp_port(resp_port), .probe_len(probe_len)
);

// File: tb/lpm_bsearch_lookup_tb_top.sv
`timescale 1ns/1ps
module lpm_bsearch_lookup_tb_top;
  localparam int AW    = 16;
  localparam int PW    = 4;
  localparam int IDXW  = 3;
  localparam int NSLOT = 4;
  localparam int LW    = $clog2(AW + 2);
  localparam int SW    = $clog2(NSLOT);
  localparam int NB    = 1 << IDXW;
  localparam int NR    = 10;
  localparam int MAXP  = $clog2(AW) + 1;

  logic clk, rst_n;
  logic req_valid, req_ready, resp_valid, resp_ready, resp_hit;
  logic [AW-1:0] req_addr, cfg_key;
  logic [PW-1:0] resp_port, cfg_port;
  logic cfg_wr, cfg_live, cfg_has_port;
  logic [LW-1:0] cfg_len;
  logic [SW-1:0] cfg_slot;

  int n_checks = 0;
  int n_errors = 0;

  lpm_bsearch_lookup #(.AW(AW), .PW(PW), .IDXW(IDXW), .NSLOT(NSLOT)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_hit(resp_hit), .resp_port(resp_port),
    .cfg_wr(cfg_wr), .cfg_len(cfg_len), .cfg_slot(cfg_slot), .cfg_key(cfg_key),
    .cfg_live(cfg_live), .cfg_has_port(cfg_has_port), .cfg_port(cfg_port)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // route set
  logic [AW-1:0] rt_key  [NR];
  int            rt_len  [NR];
  logic [PW-1:0] rt_port [NR];

  // software copy of table occupancy
  logic          sw_live [AW+1][NB][NSLOT];
  logic [AW-1:0] sw_key  [AW+1][NB][NSLOT];

  function automatic logic [AW-1:0] pmask(input int l);
    logic [AW-1:0] m = '0;
    for (int i = 0; i < l; i++) m[AW-1-i] = 1'b1;
    return m;
  endfunction

  function automatic int fold(input logic [AW-1:0] k);
    int r = 0;
    for (int i = 0; i < AW; i += IDXW) r = r ^ ((int'(k) >> i) & (NB - 1));
    return r;
  endfunction

  function automatic logic [PW:0] ref_lpm(input logic [AW-1:0] a, input int maxl);
    int bl = -1;
    logic [PW-1:0] bp = '0;
    for (int r = 0; r < NR; r++) begin
      if (rt_len[r] <= maxl && rt_len[r] > bl && ((a & pmask(rt_len[r])) == rt_key[r])) begin
        bl = rt_len[r];
        bp = rt_port[r];
      end
    end
    return {(bl >= 0), bp};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic alloc(input int l, input logic [AW-1:0] k, output int s);
    int b = fold(k);
    s = -1;
    for (int i = 0; i < NSLOT; i++)
      if (s < 0 && sw_live[l][b][i] && sw_key[l][b][i] == k) s = i;
    for (int i = 0; i < NSLOT; i++)
      if (s < 0 && !sw_live[l][b][i]) s = i;
    if (s < 0) begin
      check(1'b0, "R5 setup bucket full", l, b);
      s = 0;
    end
    sw_live[l][b][s] = 1'b1;
    sw_key[l][b][s]  = k;
  endtask

  task automatic cfg_write(input int l, input int s, input logic [AW-1:0] k,
                           input bit live, input bit hp, input logic [PW-1:0] p);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_len = LW'(l); cfg_slot = SW'(s); cfg_key = k;
    cfg_live = live; cfg_has_port = hp; cfg_port = p;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic lookup(input logic [AW-1:0] a, output logic h, output logic [PW-1:0] p,
                        output int probes);
    int lat;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!resp_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    h = resp_hit; p = resp_port; probes = lat - 1;
  endtask

  task automatic lookup_chk(input logic [AW-1:0] a, input string req);
    logic h; logic [PW-1:0] p; int pr;
    logic [PW:0] e;
    e = ref_lpm(a, AW);
    lookup(a, h, p, pr);
    check(h == e[PW], {req, " hit"}, int'(h), int'(e[PW]));
    if (e[PW]) check(p == e[PW-1:0], {req, " port"}, int'(p), int'(e[PW-1:0]));
    check(pr >= 1 && pr <= MAXP, "R3 probe count", pr, MAXP);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic h; logic [PW-1:0] p; int pr; int s9;
    logic [PW:0] e;
    logic [PW-1:0] held;

    rt_key[0] = 16'h0000; rt_len[0] = 1;  rt_port[0] = 4'd4;
    rt_key[1] = 16'hC000; rt_len[1] = 2;  rt_port[1] = 4'd7;
    rt_key[2] = 16'h4000; rt_len[2] = 3;  rt_port[2] = 4'd8;
    rt_key[3] = 16'h8000; rt_len[3] = 4;  rt_port[3] = 4'd5;
    rt_key[4] = 16'h8200; rt_len[4] = 8;  rt_port[4] = 4'd1;
    rt_key[5] = 16'h8240; rt_len[5] = 10; rt_port[5] = 4'd3;
    rt_key[6] = 16'h1230; rt_len[6] = 12; rt_port[6] = 4'd2;
    rt_key[7] = 16'h1234; rt_len[7] = 16; rt_port[7] = 4'd9;
    rt_key[8] = 16'hA5A0; rt_len[8] = 13; rt_port[8] = 4'd6;
    rt_key[9] = 16'h6F00; rt_len[9] = 9;  rt_port[9] = 4'd10;

    for (int l = 0; l <= AW; l++)
      for (int b = 0; b < NB; b++)
        for (int s = 0; s < NSLOT; s++) begin
          sw_live[l][b][s] = 1'b0;
          sw_key[l][b][s]  = '0;
        end

    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; resp_ready = 1'b1;
    cfg_wr = 1'b0; cfg_len = '0; cfg_slot = '0; cfg_key = '0;
    cfg_live = 1'b0; cfg_has_port = 1'b0; cfg_port = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
    check(resp_valid == 1'b0, "R1 resp_valid", int'(resp_valid), 0);

    // empty tables: miss, 4 probes on the all-miss path
    lookup(16'h9000, h, p, pr);
    check(h == 1'b0, "R2 empty miss", int'(h), 0);
    check(pr == 4, "R3 all-miss probes", pr, 4);

    // build real entries and markers along each route's search path
    for (int r = 0; r < NR; r++) begin
      int lo, hi, mid, s;
      alloc(rt_len[r], rt_key[r], s);
      lo = 1; hi = AW;
      while (lo <= hi) begin
        mid = (lo + hi) / 2;
        if (mid == rt_len[r]) break;
        if (mid < rt_len[r]) begin
          alloc(mid, rt_key[r] & pmask(mid), s);
          lo = mid + 1;
        end else hi = mid - 1;
      end
    end
    for (int l = 1; l <= AW; l++)
      for (int b = 0; b < NB; b++)
        for (int s = 0; s < NSLOT; s++)
          if (sw_live[l][b][s]) begin
            e = ref_lpm(sw_key[l][b][s], l);
            cfg_write(l, s, sw_key[l][b][s], 1'b1, e[PW], e[PW-1:0]);
          end

    // nested routes: /10 wins over /8 and /4
    lookup(16'h8250, h, p, pr);
    check(h && p == 4'd3, "R2 nested longest", int'(p), 3);
    // /10 misses, falls back to /8
    lookup(16'h8280, h, p, pr);
    check(h && p == 4'd1, "R4 fallback to shorter", int'(p), 1);
    // marker hits at 14,15 carry /12 port, full match fails
    lookup(16'h1235, h, p, pr);
    check(h && p == 4'd2, "R4 marker port", int'(p), 2);
    // full-length route, worst-case path
    lookup(16'h1234, h, p, pr);
    check(h && p == 4'd9, "R2 full length", int'(p), 9);
    check(pr == MAXP, "R3 worst-case probes", pr, MAXP);
    // marker without port, then miss longer
    lookup(16'hA5FF, h, p, pr);
    check(h == 1'b0, "R4 portless marker miss", int'(h), 0);
    lookup(16'hA5A7, h, p, pr);
    check(h && p == 4'd6, "R5 hashed /13 route", int'(p), 6);

    // sweep all top-12-bit combinations
    for (int i = 0; i < 4096; i++)
      lookup_chk(AW'(i * 16 + (i % 16)), "R2 sweep");

    // R9 response held while not taken
    resp_ready = 1'b0;
    lookup(16'h8250, h, p, pr);
    held = p;
    repeat (3) @(negedge clk);
    check(resp_valid == 1'b1, "R9 valid held", int'(resp_valid), 1);
    check(resp_port == held && resp_hit, "R9 port held", int'(resp_port), int'(held));
    check(req_ready == 1'b0, "R9 busy until taken", int'(req_ready), 0);
    resp_ready = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && resp_valid == 1'b0, "R9 release", int'(req_ready), 1);

    // R8 write during a search is dropped
    alloc(4, 16'h9000, s9);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h9000;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_wr = 1'b1; cfg_len = LW'(4); cfg_slot = SW'(s9); cfg_key = 16'h9000;
    cfg_live = 1'b1; cfg_has_port = 1'b1; cfg_port = 4'd11;
    @(negedge clk);
    cfg_wr = 1'b0;
    while (!resp_valid) @(negedge clk);
    @(negedge clk);
    lookup(16'h9000, h, p, pr);
    check(h == 1'b0, "R8 busy write ignored", int'(h), 0);

    // R6 low key bits dropped on write
    cfg_write(4, s9, 16'h9ABC, 1'b1, 1'b1, 4'd11);
    lookup(16'h9000, h, p, pr);
    check(h && p == 4'd11, "R6 masked key low end", int'(p), 11);
    lookup(16'h9FFF, h, p, pr);
    check(h && p == 4'd11, "R6 masked key high end", int'(p), 11);

    // R7 delete
    cfg_write(4, s9, 16'h9000, 1'b0, 1'b0, 4'd0);
    lookup(16'h9123, h, p, pr);
    check(h == 1'b0, "R7 removed entry", int'(h), 0);
    lookup_chk(16'h8250, "R7 others kept");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule